// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block is a station management master. It reads and writes registers of an external Ethernet PHY over the two-wire management bus: a clock (MDC) that it generates and a bidirectional data line (MDIO), which it drives through an output and an output enable. Software reaches the block through a simple register port with two 32-bit words: a control word and a data word. The data word carries the value to write, or the value read back from the PHY.

To run a write, software first loads the data word. It then writes the control word with the go bit set, the write opcode, the PHY address, the register address and a clock-range code. A read starts the same way with the read opcode. The block then serializes one Clause 22 frame, with the data bits sent most significant first. It releases the data line during the turnaround and data phases of a read, and it clears the go/busy bit when the last bit time ends. Software polls that bit. After a read, the captured value is in the data word.

The clock-range code sets the MDC half period in system clocks. The code in force when a transaction starts governs that whole transaction.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both words read as zero, MDC is low and the MDIO output enable is low.
- R2: The control word (port select 0) holds the go/busy flag in bit 0, the opcode in bits 3:2, the clock-range code in bits 11:8, the register address in bits 20:16 and the PHY address in bits 25:21. The data word (port select 1) holds 16 bits in bits 15:0. Reads return the stored fields, and all other bits read as zero.
- R3: Opcode 1 runs a write frame, with the output enable high for all 64 bit times. The frame is 32 ones, start bits 01, opcode bits 01, the PHY address and then the register address (both most significant bit first), turnaround bits 10, and then the 16 data bits most significant first.
- R4: Opcode 3 runs a read frame. The first 46 bits are driven: 32 ones, start bits 01, opcode bits 10, the PHY address and the register address. The output enable is then low for the last 18 bit times.
- R5: In a read, the master samples MDIO at the MDC rising edge of bit times 48 to 63, most significant bit first. The 16-bit result is in the data word once busy reads 0.
- R6: A control write made while idle, with bit 0 set and a valid opcode, sets busy. Busy reads 1 until the high phase of the final bit has ended, and it clears only on an MDC falling edge.
- R7: A control write with bit 0 set and opcode 0 or 2 starts no frame. Busy reads 0 afterwards and MDC stays low.
- R8: The MDC half period is (range code + 1) × HALF_STEP system clocks, with HALF_STEP = 1 by default.
- R9: While busy is set, writes to the control word and to the data word are ignored. The running frame is unchanged, and no second frame follows.
- R10: During a frame, MDIO changes only when MDC falls. Whenever busy is 0, MDC and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 data word |
| wr_data | input | 32 | Register write value |
| rd_sel | input | 1 | Read target: 0 control word, 1 data word |
| rd_data | output | 32 | Selected register value |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The bench attacks the read turnaround. A master that kept driving there, or that captured data one bit time early or late, would show a wrong output-enable pattern or a shifted read value. It writes both the control and the data word in the middle of a frame, where a design that accepted those writes would corrupt the serialized address or data, or launch a second frame. It issues the two non-Clause-22 opcodes with the go bit set, which would produce MDC activity in a design that decoded only the go bit. It also measures the MDC rising-edge spacing at the range codes 0, 1, 3 and 5, where an off-by-one in the divider would show as a wrong period.

// File: rtl/mdio_cfg_pkg.sv
`timescale 1ns/1ps
package mdio_cfg_pkg;
   localparam int REG_W   = 32;
   localparam int DATA_W  = 16;
   localparam int ADDR_W  = 5;
   localparam int GO_BIT  = 0;
   localparam int OP_LSB  = 2;
   localparam int RNG_LSB = 8;
   localparam int RA_LSB  = 16;
   localparam int PA_LSB  = 21;

   typedef enum logic [1:0] {
      OPC_NONE  = 2'd0,
      OPC_WRITE = 2'd1,
      OPC_RSVD  = 2'd2,
      OPC_READ  = 2'd3
   } mgmt_op_e;

   function automatic logic op_is_valid(input logic [1:0] op);
      return (op == OPC_WRITE) || (op == OPC_READ);
   endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
`timescale 1ns/1ps
module mdio_mdc_div #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half_len,
   output logic             mdc,
   output logic             rise_now,
   output logic             fall_now
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic             phase_end;

   assign phase_end = run && (cnt_q == (half_len - ONE));
   assign rise_now  = phase_end && !mdc_q;
   assign fall_now  = phase_end && mdc_q;
   assign mdc       = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (phase_end) begin
         cnt_q <= '0;
         mdc_q <= !mdc_q;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq #(
   parameter int PRE_LEN = 32,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_op,
   input  logic [ADDR_W-1:0] pa,
   input  logic [ADDR_W-1:0] ra,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_now,
   input  logic              fall_now,
   input  logic              mdio_in,
   output logic              running,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   localparam int FL       = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
   localparam int IDX_W    = $clog2(FL);
   localparam int TA_IDX   = FL - DATA_W - 2;
   localparam int DATA_IDX = FL - DATA_W;
   localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FL - 1);
   localparam logic [IDX_W-1:0] TA_I   = IDX_W'(TA_IDX);
   localparam logic [IDX_W-1:0] DAT_I  = IDX_W'(DATA_IDX);

   logic [FL-1:0]     sh_q;
   logic [FL-1:0]     frame_w;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  nxt_idx;
   logic              run_q, rd_q, drv_q, oe_q;
   logic [DATA_W-1:0] cap_q;
   logic              last_bit;

   assign frame_w  = {{PRE_LEN{1'b1}}, 2'b01,
                      (rd_op ? 2'b10 : 2'b01), pa, ra,
                      (rd_op ? 2'b11 : 2'b10),
                      (rd_op ? {DATA_W{1'b1}} : wdata)};
   assign nxt_idx  = idx_q + IDX_W'(1);
   assign last_bit = (idx_q == LAST_I);
   assign done     = run_q && fall_now && last_bit;
   assign running  = run_q;
   assign mdio_o   = drv_q;
   assign mdio_oe  = oe_q;
   assign rdata    = cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '1;
         idx_q <= '0;
         run_q <= 1'b0;
         rd_q  <= 1'b0;
         drv_q <= 1'b1;
         oe_q  <= 1'b0;
         cap_q <= '0;
      end else if (start && !run_q) begin
         sh_q  <= frame_w;
         idx_q <= '0;
         run_q <= 1'b1;
         rd_q  <= rd_op;
         drv_q <= frame_w[FL-1];
         oe_q  <= 1'b1;
      end else if (run_q) begin
         if (rise_now && rd_q && (idx_q >= DAT_I))
            cap_q <= {cap_q[DATA_W-2:0], mdio_in};
         if (fall_now) begin
            if (last_bit) begin
               run_q <= 1'b0;
               oe_q  <= 1'b0;
               drv_q <= 1'b1;
            end else begin
               idx_q <= nxt_idx;
               sh_q  <= {sh_q[FL-2:0], 1'b1};
               drv_q <= sh_q[FL-2];
               oe_q  <= !rd_q || (nxt_idx < TA_I);
            end
         end
      end
   end

   // R4
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && rd_q && (idx_q >= TA_I)) |-> !oe_q);
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
   import mdio_cfg_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int RANGE_W     = 4,
   parameter int HALF_STEP   = 1,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_sel,
   output logic [REG_W-1:0] rd_data,
   output logic             mdc_o,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   localparam int CNT_W = $clog2((2 ** RANGE_W) * HALF_STEP + 1);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be at least 1");
   end
   if ((RANGE_W < 1) || (RANGE_W > 8)) begin : g_bad_rng
      $error("RANGE_W must lie in 1..8");
   end
   if ((SYNC_STAGES < 0) || (HALF_STEP <= SYNC_STAGES)) begin : g_bad_step
      $error("HALF_STEP must exceed SYNC_STAGES");
   end

   logic [1:0]         op_q;
   logic [ADDR_W-1:0]  pa_q, ra_q;
   logic [RANGE_W-1:0] rng_q;
   logic               busy_q;
   logic [DATA_W-1:0]  data_q;
   logic [REG_W-1:0]   ctrl_word;
   logic [CNT_W-1:0]   half_len;
   logic               ctl_wr, dat_wr, launch;
   logic [1:0]         wr_op;
   logic               mdio_in_s;
   logic               seq_run, seq_done, rise_now, fall_now;
   logic [DATA_W-1:0]  seq_rdata;
   logic               unused_wr;

   assign unused_wr = ^wr_data;
   assign ctl_wr    = wr_en && !wr_sel;
   assign dat_wr    = wr_en && wr_sel;
   assign wr_op     = wr_data[OP_LSB +: 2];
   assign launch    = ctl_wr && !busy_q && wr_data[GO_BIT] && op_is_valid(wr_op);
   assign half_len  = CNT_W'((int'(rng_q) + 1) * HALF_STEP);

   if (SYNC_STAGES == 0) begin : g_nosync
      assign mdio_in_s = mdio_i;
   end else begin : g_sync
      logic st_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) st_q[k] <= 1'b1;
         end else begin
            st_q[0] <= mdio_i;
            for (int k = 1; k < SYNC_STAGES; k++) st_q[k] <= st_q[k-1];
         end
      end
      assign mdio_in_s = st_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         pa_q   <= '0;
         ra_q   <= '0;
         rng_q  <= '0;
         busy_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (ctl_wr && !busy_q) begin
            op_q  <= wr_op;
            pa_q  <= wr_data[PA_LSB +: ADDR_W];
            ra_q  <= wr_data[RA_LSB +: ADDR_W];
            rng_q <= wr_data[RNG_LSB +: RANGE_W];
         end
         if (launch)
            busy_q <= 1'b1;
         else if (seq_done)
            busy_q <= 1'b0;
         if (dat_wr && !busy_q)
            data_q <= wr_data[DATA_W-1:0];
         else if (seq_done && (op_q == OPC_READ))
            data_q <= seq_rdata;
      end
   end

   always_comb begin
      ctrl_word                      = '0;
      ctrl_word[GO_BIT]              = busy_q;
      ctrl_word[OP_LSB +: 2]         = op_q;
      ctrl_word[RNG_LSB +: RANGE_W]  = rng_q;
      ctrl_word[RA_LSB +: ADDR_W]    = ra_q;
      ctrl_word[PA_LSB +: ADDR_W]    = pa_q;
   end

   assign rd_data = rd_sel ? {{(REG_W-DATA_W){1'b0}}, data_q} : ctrl_word;

   mdio_mdc_div #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (seq_run),
      .half_len (half_len),
      .mdc      (mdc_o),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (launch),
      .rd_op    (wr_op == OPC_READ),
      .pa       (wr_data[PA_LSB +: ADDR_W]),
      .ra       (wr_data[RA_LSB +: ADDR_W]),
      .wdata    (data_q),
      .rise_now (rise_now),
      .fall_now (fall_now),
      .mdio_in  (mdio_in_s),
      .running  (seq_run),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done     (seq_done),
      .rdata    (seq_rdata)
   );

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (!mdc_o && !mdio_oe));

   // R10
   mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_run && $past(seq_run) && (mdio_o != $past(mdio_o))) |-> ($past(mdc_o) && !mdc_o));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy_q) |=> ($stable(pa_q) && $stable(ra_q) && $stable(op_q) &&
                             $stable(rng_q) && $stable(data_q)));

   // R7
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !busy_q && wr_data[GO_BIT] && !wr_op[0]) |=> !busy_q);

   // R6
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(mdc_o) && !mdc_o));
endmodule

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   bit armed = 0;

   typedef struct {
      logic [63:0] bits;
      bit          rd;
      int          half;
   } exp_t;
   exp_t sb_q[$];

   logic [15:0] phy_val = '0;
   int          mon_idx = 0;
   int          rise_total = 0;
   logic [63:0] got_b, got_oe;
   longint      t_r0, t_r1;
   longint      last_fall = -1;

   always #4 clk = ~clk;

   mdio_mgmt_master uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .mdc_o(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ctl(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [3:0] rng, input bit go);
      return (32'(pa) << 21) | (32'(ra) << 16) | (32'(rng) << 8) | (32'(op) << 2) | 32'(go);
   endfunction

   function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] wd);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
              (rd ? 2'b11 : 2'b10), (rd ? 16'h0000 : wd)};
   endfunction

   task automatic score_frame();
      exp_t        e;
      logic [63:0] eoe;
      if (sb_q.size() == 0) begin
         chk(1'b0, "R9 unexpected frame", got_b, 64'h0);
      end else begin
         e   = sb_q.pop_front();
         eoe = e.rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
         chk(got_oe == eoe, e.rd ? "R4 output enable pattern" : "R3 output enable pattern", got_oe, eoe);
         chk((got_b & eoe) == (e.bits & eoe), e.rd ? "R4 read frame bits" : "R3 write frame bits",
             got_b & eoe, e.bits & eoe);
         chk((t_r1 - t_r0) == longint'(2 * e.half * 8), "R8 MDC period",
             64'(t_r1 - t_r0), 64'(2 * e.half * 8));
      end
   endtask

   // scoreboard monitor: one sample per MDC rising edge
   always @(posedge mdc) begin
      got_b[63 - mon_idx]  = mdio_o;
      got_oe[63 - mon_idx] = mdio_oe;
      if (mon_idx == 0) t_r0 = $time;
      if (mon_idx == 1) t_r1 = $time;
      mon_idx++;
      rise_total++;
      if (mon_idx == 64) begin
         mon_idx = 0;
         score_frame();
      end
   end

   // PHY model: presents read data after each MDC fall
   always @(negedge mdc) begin
      last_fall = $time;
      mdio_i = (mon_idx >= 48) ? phy_val[63 - mon_idx] : 1'b1;
   end

   // R10: MDIO output moves only with an MDC fall
   always @(mdio_o) begin : chg_mon
      longint tc;
      if (armed) begin
         tc = $time;
         #1;
         chk(tc == last_fall, "R10 MDIO change off MDC fall", 64'(tc), 64'(last_fall));
      end
   end

   task automatic reg_wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic sel, output logic [31:0] d);
      rd_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic start_op(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] pv, input logic [3:0] rng);
      exp_t        e;
      logic [31:0] v;
      e.bits  = exp_frame(op == 2'd3, pa, ra, wd);
      e.rd    = (op == 2'd3);
      e.half  = int'(rng) + 1;
      phy_val = pv;
      reg_wr(1'b1, {16'h0, wd});
      sb_q.push_back(e);
      reg_wr(1'b0, ctl(op, pa, ra, rng, 1'b1));
      reg_rd(1'b0, v);
      chk(v[0] == 1'b1, "R6 busy set after launch", 64'(v[0]), 64'h1);
   endtask

   task automatic finish_op(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] pv, input logic [3:0] rng);
      logic [31:0] v;
      int          n;
      n = 0;
      do begin
         @(negedge clk);
         reg_rd(1'b0, v);
         n++;
      end while (v[0] && n < 5000);
      chk(!v[0], "R6 busy clears", 64'(v[0]), 64'h0);
      chk(sb_q.size() == 0, "R6 frame complete before busy clears", 64'(sb_q.size()), 64'h0);
      chk(!mdc && !mdio_oe, "R10 MDC and enable low when idle", {mdc, mdio_oe}, 64'h0);
      chk(v == ctl(op, pa, ra, rng, 1'b0), "R2 control readback", v, ctl(op, pa, ra, rng, 1'b0));
      reg_rd(1'b1, v);
      if (op == 2'd3)
         chk(v == {16'h0, pv}, "R5 read data captured", v, {16'h0, pv});
      else
         chk(v == {16'h0, wd}, "R2 data word kept", v, {16'h0, wd});
   endtask

   task automatic full_op(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] pv, input logic [3:0] rng);
      start_op(op, pa, ra, wd, pv, rng);
      finish_op(op, pa, ra, wd, pv, rng);
   endtask

   initial begin
      logic [31:0] v;
      int          rt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      armed = 1'b1;
      @(negedge clk);
      // R1 reset state
      reg_rd(1'b0, v);
      chk(v == 32'h0, "R1 control word after reset", v, 32'h0);
      reg_rd(1'b1, v);
      chk(v == 32'h0, "R1 data word after reset", v, 32'h0);
      chk(!mdc && !mdio_oe, "R1 MDC and enable low after reset", {mdc, mdio_oe}, 64'h0);

      // R3 R5 R8 frames at several ranges and patterns
      full_op(2'd1, 5'h01, 5'h1F, 16'hA55A, 16'h0000, 4'd1);
      full_op(2'd3, 5'h1E, 5'h00, 16'h0000, 16'hC3A5, 4'd0);
      full_op(2'd3, 5'h15, 5'h0A, 16'h0000, 16'h8001, 4'd5);
      full_op(2'd1, 5'h00, 5'h00, 16'hFFFF, 16'h0000, 4'd5);
      full_op(2'd3, 5'h1F, 5'h1F, 16'h0000, 16'h0000, 4'd3);
      full_op(2'd1, 5'h0A, 5'h15, 16'h0001, 16'h0000, 4'd0);

      // R9 writes while busy are ignored
      start_op(2'd1, 5'h03, 5'h04, 16'h1234, 16'h0000, 4'd2);
      repeat (100) @(negedge clk);
      reg_wr(1'b0, ctl(2'd3, 5'h07, 5'h09, 4'd1, 1'b1));
      reg_wr(1'b1, 32'h0000_BEEF);
      reg_rd(1'b0, v);
      chk(v == ctl(2'd1, 5'h03, 5'h04, 4'd2, 1'b1), "R9 control write while busy", v,
          ctl(2'd1, 5'h03, 5'h04, 4'd2, 1'b1));
      reg_rd(1'b1, v);
      chk(v == 32'h0000_1234, "R9 data write while busy", v, 32'h0000_1234);
      finish_op(2'd1, 5'h03, 5'h04, 16'h1234, 16'h0000, 4'd2);
      rt = rise_total;
      repeat (300) @(negedge clk);
      chk(rise_total == rt, "R9 no second frame", 64'(rise_total), 64'(rt));

      // R7 non-Clause-22 opcodes start nothing
      for (int k = 0; k < 2; k++) begin
         rt = rise_total;
         reg_wr(1'b0, ctl(k == 0 ? 2'd0 : 2'd2, 5'h11, 5'h02, 4'd1, 1'b1));
         reg_rd(1'b0, v);
         chk(v[0] == 1'b0, "R7 busy stays clear on invalid opcode", 64'(v[0]), 64'h0);
         repeat (200) @(negedge clk);
         chk(rise_total == rt && !mdc, "R7 no MDC activity on invalid opcode",
             64'(rise_total), 64'(rt));
      end

      // a valid frame still runs afterwards
      full_op(2'd3, 5'h12, 5'h0C, 16'h0000, 16'h5A0F, 4'd1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule